// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit runs one indivisible read-modify-write operation at a time against a single-ported word memory. A requester presents an operation code, a word address, a source operand, a comparand, a carry input, a lock flag and two operand-kind bits. The operand-kind bits say whether the destination is a memory word and whether the source came from memory. The unit first checks whether the lock flag is legal for that request. An illegal request is answered with an undefined-opcode fault and never touches memory. A legal request reads the addressed word and computes the new value in the read-grant cycle. It then stores the result and returns the prior word together with a one-bit flag.

For a locked operation, the unit keeps its memory request and a lock line high from the first read request until the write is granted, so no other agent reaches memory in between. Unlocked operations use the same ALU path but drop the request for one cycle between read and write. Exchange with a memory destination is always locked. A compare-exchange whose comparand does not match skips the store.

Top module: `atom_rmw_unit`

## Requirements
- R1: Operation codes are: 0 add, 1 add with carry-in, 2 subtract, 3 subtract with borrow-in, 4 and, 5 or, 6 xor, 7 invert, 8 negate, 9 increment, 10 decrement, 11 bit set, 12 bit reset, 13 bit invert, 14 exchange, 15 exchange-add, 16 compare-exchange, 17 plain move. The word stored is that operation applied to the old word and the source, modulo 2^W.
- R2: Every memory operation returns the word held before it in rsp_old. Exchange-add stores old plus source.
- R3: Compare-exchange stores the source and sets rsp_bit when the old word equals the comparand. Otherwise it issues no write and clears rsp_bit.
- R4: The bit operations use the source modulo W as the bit index, return the old bit in rsp_bit, and set, reset or invert that bit.
- R5: Codes 0 to 16 are lock-capable. A lock flag on code 17, or any code above 17, gives rsp_fault with no memory access, and done comes one cycle after acceptance.
- R6: A lock flag with req_dst_mem low, or with req_src_mem high, also gives the fault of R5 with no memory access.
- R7: Exchange with req_dst_mem high runs locked even when req_lock is low.
- R8: In a locked operation, mem_req and mem_lock stay high without a break from the read request through the write grant. mem_addr and mem_we hold while a request waits for its grant.
- R9: In an unlocked operation, mem_lock stays low and mem_req is low for exactly one cycle between the read grant and the write request.
- R10: done is a one-cycle pulse. It comes the cycle after the write grant, or the cycle after the read grant when compare-exchange skips its write.
- R11: An unlocked request with req_dst_mem low makes no memory access and gives done the next cycle, with rsp_old 0 and rsp_fault 0.
- R12: A request is taken only while busy is low. req_valid during busy is ignored.
- R13: After reset, busy, done, mem_req and mem_lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 5 | Operation code |
| req_addr | input | AW | Word address |
| req_src | input | W | Source operand or bit index |
| req_cmp | input | W | Comparand for compare-exchange |
| req_cin | input | 1 | Carry or borrow in |
| req_lock | input | 1 | Lock flag |
| req_dst_mem | input | 1 | Destination is a memory word |
| req_src_mem | input | 1 | Source operand came from memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| rsp_old | output | W | Word before the operation |
| rsp_bit | output | 1 | Old bit or compare success |
| rsp_fault | output | 1 | Undefined-opcode fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Memory held for this unit |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with the grant |
| mem_gnt | input | 1 | Access granted this cycle |

## Verification
A wrong sequencer state shows up at the memory port within one cycle. Typical signs are a dropped request or a raised lock during an unlocked run, a gap inside a locked run, or a write after a failed compare. A stale or miscomputed result register shows up on rsp_old or rsp_bit at the done pulse. It also shows up one cycle after the write grant in the bench memory. A wrong legality decision shows as a memory request in the cycle after acceptance, where a fault was due instead. The bench stalls grants in several patterns, so that waiting states are exercised as well as the grant-at-once path.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int OPW = 5;

  localparam logic [OPW-1:0] OP_ADD  = 5'd0;
  localparam logic [OPW-1:0] OP_ADC  = 5'd1;
  localparam logic [OPW-1:0] OP_SUB  = 5'd2;
  localparam logic [OPW-1:0] OP_SBB  = 5'd3;
  localparam logic [OPW-1:0] OP_AND  = 5'd4;
  localparam logic [OPW-1:0] OP_OR   = 5'd5;
  localparam logic [OPW-1:0] OP_XOR  = 5'd6;
  localparam logic [OPW-1:0] OP_NOT  = 5'd7;
  localparam logic [OPW-1:0] OP_NEG  = 5'd8;
  localparam logic [OPW-1:0] OP_INC  = 5'd9;
  localparam logic [OPW-1:0] OP_DEC  = 5'd10;
  localparam logic [OPW-1:0] OP_BSET = 5'd11;
  localparam logic [OPW-1:0] OP_BCLR = 5'd12;
  localparam logic [OPW-1:0] OP_BINV = 5'd13;
  localparam logic [OPW-1:0] OP_SWAP = 5'd14;
  localparam logic [OPW-1:0] OP_SWAD = 5'd15;
  localparam logic [OPW-1:0] OP_CMPX = 5'd16;
  localparam logic [OPW-1:0] OP_MOVE = 5'd17;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_GAP, ST_WRITE, ST_DONE
  } atom_st_e;

  function automatic logic op_lockable(input logic [OPW-1:0] op);
    return op <= OP_CMPX;
  endfunction

  function automatic logic op_defined(input logic [OPW-1:0] op);
    return op <= OP_MOVE;
  endfunction
endpackage

// File: rtl/atom_gate.sv
module atom_gate
  import atom_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           lock_flag,
  input  logic           dst_mem,
  input  logic           src_mem,
  output logic           fault,
  output logic           locked,
  output logic           mem_work
);
  logic implied_lock;
  logic lock_misuse;

  assign implied_lock = (op == OP_SWAP) && dst_mem;
  assign lock_misuse  = lock_flag && (!op_lockable(op) || !dst_mem || src_mem);
  assign fault        = !op_defined(op) || lock_misuse;
  assign locked       = (lock_flag || implied_lock) && !fault;
  assign mem_work     = dst_mem && !fault;
endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   cmp,
  input  logic           cin,
  output logic [W-1:0]   nxt,
  output logic           flag,
  output logic           store
);
  localparam int BW = $clog2(W);

  function automatic logic [W-1:0] add_c(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
    return a + b + {{(W-1){1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] sub_b(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
    return a - b - {{(W-1){1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] one_hot(input logic [BW-1:0] idx);
    logic [W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  logic [BW-1:0] bidx;
  logic [W-1:0]  bmask;
  logic          equal;

  assign bidx  = src[BW-1:0];
  assign bmask = one_hot(bidx);
  assign equal = (cur == cmp);

  always_comb begin
    nxt  = cur;
    flag = 1'b0;
    case (op)
      OP_ADD:  nxt = add_c(cur, src, 1'b0);
      OP_ADC:  nxt = add_c(cur, src, cin);
      OP_SUB:  nxt = sub_b(cur, src, 1'b0);
      OP_SBB:  nxt = sub_b(cur, src, cin);
      OP_AND:  nxt = cur & src;
      OP_OR:   nxt = cur | src;
      OP_XOR:  nxt = cur ^ src;
      OP_NOT:  nxt = ~cur;
      OP_NEG:  nxt = sub_b('0, cur, 1'b0);
      OP_INC:  nxt = add_c(cur, '0, 1'b1);
      OP_DEC:  nxt = sub_b(cur, '0, 1'b1);
      OP_BSET: begin nxt = cur | bmask;  flag = cur[bidx]; end
      OP_BCLR: begin nxt = cur & ~bmask; flag = cur[bidx]; end
      OP_BINV: begin nxt = cur ^ bmask;  flag = cur[bidx]; end
      OP_SWAP: nxt = src;
      OP_SWAD: nxt = add_c(cur, src, 1'b0);
      OP_CMPX: begin nxt = equal ? src : cur; flag = equal; end
      OP_MOVE: nxt = src;
      default: nxt = cur;
    endcase
  end

  assign store = !((op == OP_CMPX) && !equal);
endmodule

// File: rtl/atom_ctl.sv
module atom_ctl
  import atom_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     go_mem,
  input  logic     locked,
  input  logic     skip_write,
  input  logic     gnt,
  output atom_st_e state,
  output logic     rd_fire,
  output logic     wr_fire
);
  atom_st_e nstate;

  assign rd_fire = (state == ST_READ)  && gnt;
  assign wr_fire = (state == ST_WRITE) && gnt;

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE:  if (start) nstate = go_mem ? ST_READ : ST_DONE;
      ST_READ:  if (gnt) nstate = skip_write ? ST_DONE : (locked ? ST_WRITE : ST_GAP);
      ST_GAP:   nstate = ST_WRITE;
      ST_WRITE: if (gnt) nstate = ST_DONE;
      ST_DONE:  nstate = ST_IDLE;
      default:  nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nstate;
  end

  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |=> (state == ST_WRITE)); // R9
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R10
endmodule

// File: rtl/atom_rmw_unit.sv
module atom_rmw_unit
  import atom_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [4:0]     req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [W-1:0]   req_src,
  input  logic [W-1:0]   req_cmp,
  input  logic           req_cin,
  input  logic           req_lock,
  input  logic           req_dst_mem,
  input  logic           req_src_mem,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   rsp_old,
  output logic           rsp_bit,
  output logic           rsp_fault,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_lock,
  output logic [AW-1:0]  mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  input  logic           mem_gnt
);
  atom_st_e        state;
  logic            accept;
  logic            fault_det, locked_det, work_det;
  logic            rd_fire, wr_fire;
  logic [OPW-1:0]  op_q;
  logic [AW-1:0]   addr_q;
  logic [W-1:0]    src_q, cmp_q, old_q, new_q;
  logic            cin_q, lock_q, fault_q, bit_q;
  logic [W-1:0]    alu_nxt;
  logic            alu_flag, alu_store;

  assign accept = req_valid && (state == ST_IDLE);

  atom_gate u_gate (
    .op        (req_op),
    .lock_flag (req_lock),
    .dst_mem   (req_dst_mem),
    .src_mem   (req_src_mem),
    .fault     (fault_det),
    .locked    (locked_det),
    .mem_work  (work_det)
  );

  atom_alu #(.W(W)) u_alu (
    .op    (op_q),
    .cur   (mem_rdata),
    .src   (src_q),
    .cmp   (cmp_q),
    .cin   (cin_q),
    .nxt   (alu_nxt),
    .flag  (alu_flag),
    .store (alu_store)
  );

  atom_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .go_mem     (work_det),
    .locked     (lock_q),
    .skip_write (!alu_store),
    .gnt        (mem_gnt),
    .state      (state),
    .rd_fire    (rd_fire),
    .wr_fire    (wr_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      cmp_q   <= '0;
      cin_q   <= 1'b0;
      lock_q  <= 1'b0;
      fault_q <= 1'b0;
      old_q   <= '0;
      new_q   <= '0;
      bit_q   <= 1'b0;
    end else if (accept) begin
      op_q    <= req_op;
      addr_q  <= req_addr;
      src_q   <= req_src;
      cmp_q   <= req_cmp;
      cin_q   <= req_cin;
      lock_q  <= locked_det;
      fault_q <= fault_det;
      old_q   <= '0;
      new_q   <= '0;
      bit_q   <= 1'b0;
    end else if (rd_fire) begin
      old_q   <= mem_rdata;
      new_q   <= alu_nxt;
      bit_q   <= alu_flag;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign rsp_old   = old_q;
  assign rsp_bit   = bit_q;
  assign rsp_fault = fault_q;
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_lock  = lock_q && ((state == ST_READ) || (state == ST_WRITE));
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;

  AST_LOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> mem_req); // R8
  AST_LOCKED_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_lock && !mem_we && mem_gnt) |=> (mem_req || done)); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
  AST_UNLOCKED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_lock && !mem_we && mem_gnt) |=> !mem_req); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt) |=> (done && !mem_req)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fault_det) |=> (done && rsp_fault && !mem_req)); // R5
  AST_SWAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == OP_SWAP) && req_dst_mem && !req_src_mem) |=> mem_lock); // R7
  AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mem_addr)); // R12
endmodule

// File: tb/sim_atom_rmw_unit.sv
module sim_atom_rmw_unit;
  localparam int W  = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [4:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_src = '0, req_cmp = '0;
  logic          req_cin = 1'b0, req_lock = 1'b0, req_dst_mem = 1'b0, req_src_mem = 1'b0;
  logic          busy, done, rsp_bit, rsp_fault;
  logic [W-1:0]  rsp_old;
  logic          mem_req, mem_we, mem_lock;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata, mem_rdata;
  logic          mem_gnt = 1'b0;
  logic [W-1:0]  mem [16];

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 4 ns period, 250 MHz

  atom_rmw_unit #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_src(req_src), .req_cmp(req_cmp), .req_cin(req_cin),
    .req_lock(req_lock), .req_dst_mem(req_dst_mem), .req_src_mem(req_src_mem),
    .busy(busy), .done(done), .rsp_old(rsp_old), .rsp_bit(rsp_bit),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1357_0000 + i * 32'h0102_0381;
    end else if (mem_req && mem_we && mem_gnt) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit gnt_of(input int mode, input int k);
    case (mode)
      0: return 1'b1;
      1: return (k % 3) == 2;
      default: return k >= 3;
    endcase
  endfunction

  // reference: {flag, new word}
  function automatic logic [W:0] ref_op(input int op, input logic [W-1:0] m,
                                        input logic [W-1:0] s, input logic [W-1:0] c,
                                        input bit cin);
    logic [W-1:0] n;
    logic         b;
    int           idx;
    idx = int'(s % W);
    b = 1'b0;
    n = m;
    if (op == 0 || op == 15) n = m + s;
    else if (op == 1) n = m + s + W'(cin);
    else if (op == 2) n = m - s;
    else if (op == 3) n = m - s - W'(cin);
    else if (op == 4) n = m & s;
    else if (op == 5) n = m | s;
    else if (op == 6) n = m ^ s;
    else if (op == 7) n = ~m;
    else if (op == 8) n = W'(0) - m;
    else if (op == 9) n = m + 1;
    else if (op == 10) n = m - 1;
    else if (op >= 11 && op <= 13) begin
      b = m[idx];
      n = m;
      if (op == 11) n[idx] = 1'b1;
      else if (op == 12) n[idx] = 1'b0;
      else n[idx] = ~m[idx];
    end else if (op == 14 || op == 17) n = s;
    else if (op == 16) begin
      b = (m == c);
      n = b ? s : m;
    end
    return {b, n};
  endfunction

  task automatic run(input string tag, input int op, input int addr, input logic [W-1:0] src,
                     input logic [W-1:0] cmp, input bit cin, input bit lock, input bit dmem,
                     input bit smem, input int gmode, input bit poke);
    bit exp_fault, exp_locked, exp_mem, exp_wr;
    logic [W-1:0] old_v, exp_new, poke_before;
    logic [W:0] r;
    int rd_k, wr_k, done_k, nreq, gap, lock_bad;
    logic [W-1:0] got_old;
    logic got_bit, got_fault;
    exp_fault  = (op > 17) || (lock && (op > 16 || !dmem || smem));
    exp_locked = !exp_fault && (lock || (op == 14 && dmem));
    exp_mem    = dmem && !exp_fault;
    old_v      = exp_mem ? mem[addr] : '0;
    r          = ref_op(op, old_v, src, cmp, cin);
    exp_wr     = exp_mem && !(op == 16 && old_v != cmp);
    exp_new    = exp_wr ? r[W-1:0] : old_v;
    poke_before = mem[(addr + 7) % 16];
    rd_k = -1; wr_k = -1; done_k = -1; nreq = 0; gap = 0; lock_bad = 0;
    got_old = '0; got_bit = 1'b0; got_fault = 1'b0;

    @(posedge clk); #1;
    req_valid = 1'b1; req_op = 5'(op); req_addr = AW'(addr); req_src = src; req_cmp = cmp;
    req_cin = cin; req_lock = lock; req_dst_mem = dmem; req_src_mem = smem;
    @(posedge clk); #1;
    req_valid = poke;
    if (poke) begin
      req_op = 5'd17; req_addr = AW'((addr + 7) % 16); req_src = 32'hDEAD_BEEF;
      req_lock = 1'b0; req_dst_mem = 1'b1; req_src_mem = 1'b0;
    end
    mem_gnt = gnt_of(gmode, 0);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (mem_req) begin
        nreq++;
        if (mem_lock != exp_locked) lock_bad++;
        if (mem_gnt) begin
          if (mem_we) wr_k = k; else rd_k = k;
        end
      end else if (rd_k >= 0 && wr_k < 0 && !done) begin
        gap++;
      end
      if (done) begin
        done_k = k; got_old = rsp_old; got_bit = rsp_bit; got_fault = rsp_fault;
        break;
      end
      @(posedge clk); #1;
      if (k >= 1) req_valid = 1'b0;
      mem_gnt = gnt_of(gmode, k + 1);
    end
    req_valid = 1'b0;
    mem_gnt = 1'b0;
    chk(got_fault == exp_fault, tag, "fault flag", W'(got_fault), W'(exp_fault));
    if (!exp_mem) begin
      chk(nreq == 0, tag, "memory requests", W'(nreq), 0);
      chk(done_k == 0, tag, "done cycle", W'(done_k), 0);
      chk(got_old == '0, tag, "old value", got_old, '0);
    end else begin
      chk(got_old == old_v, tag, "old value", got_old, old_v);
      chk(got_bit == r[W], tag, "result bit", W'(got_bit), W'(r[W]));
      @(negedge clk);
      chk(mem[addr] == exp_new, tag, "stored word", mem[addr], exp_new);
      chk((wr_k >= 0) == exp_wr, tag, "write issued", W'(wr_k >= 0), W'(exp_wr));
      chk(done_k == (exp_wr ? wr_k : rd_k) + 1, "R10", "done one cycle after last grant",
          W'(done_k), W'((exp_wr ? wr_k : rd_k) + 1));
      chk(lock_bad == 0, exp_locked ? "R8" : "R9", "lock line level", W'(lock_bad), 0);
      if (exp_locked)
        chk(gap == 0, "R8", "request gap in locked run", W'(gap), 0);
      else if (exp_wr)
        chk(gap == 1, "R9", "release cycles in unlocked run", W'(gap), 1);
    end
    @(negedge clk);
    chk(!done, "R10", "done pulse width", W'(done), 0);
    if (poke) begin
      nreq = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (mem_req || busy) nreq++;
      end
      chk(nreq == 0, "R12", "request during busy started work", W'(nreq), 0);
      chk(mem[(addr + 7) % 16] == poke_before, "R12", "word touched by ignored request",
          mem[(addr + 7) % 16], poke_before);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R13", "busy after reset", W'(busy), 0);
    chk(!done, "R13", "done after reset", W'(done), 0);
    chk(!mem_req, "R13", "mem_req after reset", W'(mem_req), 0);
    chk(!mem_lock, "R13", "mem_lock after reset", W'(mem_lock), 0);

    run("R1", 0, 1, 32'h0000_0005, '0, 0, 1, 1, 0, 1, 0);
    run("R1", 1, 2, 32'hFFFF_FFFF, '0, 1, 1, 1, 0, 0, 0);
    run("R1", 2, 3, 32'h1234_5678, '0, 0, 0, 1, 0, 0, 0);
    run("R1", 3, 4, 32'h8000_0001, '0, 1, 0, 1, 0, 1, 0);
    run("R1", 4, 5, 32'h0F0F_F0F0, '0, 0, 1, 1, 0, 0, 0);
    run("R1", 5, 6, 32'hA000_000A, '0, 0, 1, 1, 0, 1, 0);
    run("R1", 6, 7, 32'h5555_AAAA, '0, 0, 0, 1, 0, 0, 0);
    run("R1", 7, 8, '0, '0, 0, 1, 1, 0, 0, 0);
    run("R1", 8, 9, '0, '0, 0, 1, 1, 0, 0, 0);
    run("R1", 9, 10, '0, '0, 0, 1, 1, 0, 1, 0);
    run("R1", 10, 11, '0, '0, 0, 0, 1, 0, 0, 0);
    run("R2", 15, 12, 32'h0000_0100, '0, 0, 1, 1, 0, 1, 0);
    run("R3", 16, 13, 32'hCAFE_0001, mem[13], 0, 1, 1, 0, 0, 0);
    run("R3", 16, 13, 32'hCAFE_0002, 32'h0000_0000, 0, 1, 1, 0, 1, 0);
    run("R4", 11, 14, 32'd37, '0, 0, 1, 1, 0, 0, 0);
    run("R4", 12, 14, 32'd37, '0, 0, 1, 1, 0, 0, 0);
    run("R4", 13, 15, 32'd63, '0, 0, 0, 1, 0, 1, 0);
    run("R7", 14, 0, 32'h0BAD_F00D, '0, 0, 0, 1, 0, 1, 0);
    run("R1", 17, 1, 32'h7777_0000, '0, 0, 0, 1, 0, 0, 0);
    run("R5", 17, 2, 32'h1111_1111, '0, 0, 1, 1, 0, 0, 0);
    run("R5", 20, 3, 32'h2222_2222, '0, 0, 1, 1, 0, 0, 0);
    run("R6", 0, 4, 32'h3, '0, 0, 1, 0, 0, 0, 0);
    run("R6", 0, 5, 32'h3, '0, 0, 1, 1, 1, 0, 0);
    run("R11", 0, 6, 32'h3, '0, 0, 0, 0, 0, 0, 0);
    run("R12", 0, 2, 32'h40, '0, 0, 1, 1, 0, 2, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule